// File: doc/BRIEF.md
# Receive Play-out State Controller

This block sits in the receive path of a bit-stream emulation link, after the outer transport headers have been removed. For every arriving packet it is given the 32-bit control word and the measured payload length. It rejects packets with a wrong header kind or a wrong length. It follows the sequence number to find packets that are missing, late or duplicated, and it keeps a count of the payload slots that are waiting to be played. The payload bytes themselves are stored elsewhere. This block only decides what each play-out slot carries.

A play-out slot is requested by a one-cycle strobe. One cycle later the block answers with a selection: buffered data, replacement data (the fixed byte pattern 0xAA in place of a lost payload), or a native fault indication. The connection state machine has four states. DOWN holds while the connection is not up. PREFILL collects a configured number of payloads before play-out starts. NORMAL plays from the buffer. LOSS is entered when no well-formed packet has arrived for a configured number of cycles, and it needs a fresh prefill before play-out resumes. The named transitions are: link-up (DOWN to PREFILL), prefill-done (PREFILL to NORMAL), timeout (NORMAL to LOSS), refill-done (LOSS to NORMAL) and link-drop (any state to DOWN).

The controller drives a fault-injection request to the native side and a loss flag, which the local transmitter copies into the R bit of its outgoing control words. It also gives one-cycle events for each accepted packet and for each replacement slot played in place of a lost packet.

Top module: `plc_playout_ctrl`

## Requirements
- R1: After reset the state is DOWN, so `fault_req` is 1 and `loss_flag`, `play_valid`, `rx_evt` and `lost_evt` are 0.
- R2: A packet is used only if control word bits [31:28] are 0000. The L flag is bit 27 and the sequence number is bits [15:0]. Bits [26:16] (R flag, reserved, fragment and length fields) have no effect.
- R3: A packet whose `pkt_len` differs from `cfg_len` is discarded and produces no `rx_evt`.
- R4: While `link_up` is 0 the next state is DOWN, the buffer is emptied and the expected sequence number is forgotten. Packets seen in DOWN are ignored and slots in DOWN play fault (`play_sel` = 0).
- R5: In PREFILL every slot plays fault and nothing is consumed. The state moves to NORMAL on the edge after the buffered payload count reaches `cfg_prefill`.
- R6: In NORMAL, a `slot_req` gives `play_valid` on the next cycle. Buffered payloads come out in arrival order, and a data payload has `play_sel` = 1. Sequence numbers wrap from 0xFFFF to 0.
- R7: A forward sequence gap of k schedules k replacement slots (`play_sel` = 2, each with `lost_evt`) ahead of the packet. k is capped at DEPTH minus the occupancy minus 1. A packet that arrives when the buffer is full is dropped, but the expected sequence number still advances past it.
- R8: A packet whose sequence number is older than expected (difference modulo 2^16 of at least 2^15) is discarded as late: no slot and no `rx_evt`.
- R9: A packet with the L flag set occupies one slot that plays fault instead of data.
- R10: If NORMAL sees no well-formed packet for `cfg_timeout` consecutive cycles, it enters LOSS. The buffer is emptied, the expected sequence number is forgotten and slots play fault. LOSS returns to NORMAL only after the prefill count is met again.
- R11: `fault_req` is 1 outside NORMAL or while `deg_defect` is 1. `loss_flag` is 1 in LOSS or while `deg_defect` is 1. Under `deg_defect` a NORMAL slot plays fault but still consumes its payload.
- R12: A NORMAL slot with an empty buffer plays replacement (`play_sel` = 2) without `lost_evt`.
- R13: `rx_evt` pulses one cycle after each packet that is placed in the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up | input | 1 | Connection is operationally up |
| deg_defect | input | 1 | Degrade defect from the loss-ratio monitor |
| cfg_len | input | LEN_W | Configured payload length in bytes |
| cfg_prefill | input | CNT_W | Payload count needed before play-out |
| cfg_timeout | input | TMR_W | Packet-loss timeout in cycles |
| pkt_valid | input | 1 | Packet descriptor strobe |
| pkt_cw | input | 32 | Control word of the packet |
| pkt_len | input | LEN_W | Measured payload length |
| slot_req | input | 1 | Play-out slot request |
| play_valid | output | 1 | Slot answer valid |
| play_sel | output | 2 | 0 fault, 1 data, 2 replacement 0xAA |
| lost_evt | output | 1 | Replacement played for a lost packet |
| rx_evt | output | 1 | Packet accepted into the buffer |
| fault_req | output | 1 | Native fault indication request |
| loss_flag | output | 1 | Defect flag for the local transmitter R bit |

## Verification
Some properties are checked on every cycle. Slots outside NORMAL answer with fault. Each slot request is answered exactly one cycle later. A link drop empties the buffer, and occupancy never exceeds DEPTH. An accepted packet always had a clean header kind and a matching length, and never arrived in DOWN. The PREFILL and timeout exits happened only under their conditions. A late packet never raises `rx_evt`. Other behaviour can only be shown by the bench's scenarios, which compare against a slot-level queue model. These are the exact order and count of replacement slots for gaps, the gap cap and the full-buffer drop, sequence wrap, L-flag slots, the degrade override, underrun, and recovery from LOSS through a fresh prefill.

// File: rtl/plc_pkg.sv
package plc_pkg;

    typedef enum logic [1:0] {
        ST_DOWN    = 2'd0,
        ST_PREFILL = 2'd1,
        ST_NORMAL  = 2'd2,
        ST_LOSS    = 2'd3
    } plc_state_e;

    localparam logic [1:0] SEL_FAULT = 2'd0;
    localparam logic [1:0] SEL_DATA  = 2'd1;
    localparam logic [1:0] SEL_FILL  = 2'd2;

    localparam int SEQ_W = 16;

    // control word layout as decoded on receive
    typedef struct packed {
        logic [3:0]       kind;
        logic             lflag;
        logic             rflag;
        logic [1:0]       rsv;
        logic [1:0]       frag;
        logic [5:0]       plen;
        logic [SEQ_W-1:0] seq;
    } plc_cw_t;

endpackage

// File: rtl/plc_cw_check.sv
module plc_cw_check
    import plc_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             vld_i,
    input  logic [31:0]      cw_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [LEN_W-1:0] cfg_len_i,
    output logic             fmt_ok_o,
    output logic             lflag_o,
    output logic [SEQ_W-1:0] seq_o
);

    plc_cw_t word;
    logic    unused_cw_fields;

    assign word             = cw_i;
    assign fmt_ok_o         = vld_i && (word.kind == 4'h0) && (len_i == cfg_len_i);
    assign lflag_o          = word.lflag;
    assign seq_o            = word.seq;
    assign unused_cw_fields = ^{word.rflag, word.rsv, word.frag, word.plen};

endmodule

// File: rtl/plc_seq_track.sv
module plc_seq_track
    import plc_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             acc_i,
    input  logic [SEQ_W-1:0] seq_i,
    input  logic [CNT_W-1:0] occ_i,
    output logic             push_o,
    output logic             late_o,
    output logic [CNT_W-1:0] fill_o
);

    logic [SEQ_W-1:0] exp_q;
    logic             have_q;
    logic [SEQ_W-1:0] diff;
    logic [CNT_W-1:0] avail;
    logic [CNT_W-1:0] room;

    assign diff   = seq_i - exp_q;
    assign avail  = CNT_W'(DEPTH) - occ_i;
    assign room   = avail - 1'b1;
    assign late_o = acc_i && have_q && diff[SEQ_W-1];
    assign push_o = acc_i && !late_o && (avail != '0);

    always_comb begin
        if (!have_q) begin
            fill_o = '0;
        end else if (diff > SEQ_W'(room)) begin
            fill_o = room;
        end else begin
            fill_o = diff[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_q <= 1'b0;
            exp_q  <= '0;
        end else if (flush_i) begin
            have_q <= 1'b0;
        end else if (acc_i && !late_o) begin
            have_q <= 1'b1;
            exp_q  <= seq_i + 1'b1;
        end
    end

    AST_FILL_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> ({1'b0, occ_i} + {1'b0, fill_o}) < (CNT_W+1)'(DEPTH)); // R7

endmodule

// File: rtl/plc_slot_queue.sv
module plc_slot_queue #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             push_i,
    input  logic [CNT_W-1:0] push_fill_i,
    input  logic             push_l_i,
    input  logic             take_i,
    output logic [CNT_W-1:0] occ_o,
    output logic             empty_o,
    output logic             head_fill_o,
    output logic             head_l_o
);

    // one entry per accepted packet: replacement slots owed ahead of it, then its payload
    logic [CNT_W-1:0] fill_mem [DEPTH];
    logic             l_mem    [DEPTH];
    logic [PTR_W-1:0] rd_q, wr_q;
    logic [CNT_W-1:0] done_q;
    logic [CNT_W-1:0] occ_q;
    logic [CNT_W:0]   occ_add, occ_sub, occ_nx;
    logic             take_ok;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign occ_o       = occ_q;
    assign empty_o     = (occ_q == '0);
    assign head_fill_o = !empty_o && (done_q < fill_mem[rd_q]);
    assign head_l_o    = l_mem[rd_q];
    assign take_ok     = take_i && !empty_o;
    assign occ_add     = push_i ? ({1'b0, push_fill_i} + 1'b1) : '0;
    assign occ_sub     = take_ok ? (CNT_W+1)'(1) : '0;
    assign occ_nx      = {1'b0, occ_q} + occ_add - occ_sub;

    always_ff @(posedge clk) begin
        if (push_i && !flush_i) begin
            fill_mem[wr_q] <= push_fill_i;
            l_mem[wr_q]    <= push_l_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            rd_q   <= '0;
            wr_q   <= '0;
            done_q <= '0;
            occ_q  <= '0;
        end else begin
            occ_q <= occ_nx[CNT_W-1:0];
            if (push_i) begin
                wr_q <= bump(wr_q);
            end
            if (take_ok) begin
                if (head_fill_o) begin
                    done_q <= done_q + 1'b1;
                end else begin
                    done_q <= '0;
                    rd_q   <= bump(rd_q);
                end
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= CNT_W'(DEPTH)); // R7

endmodule

// File: rtl/plc_playout_ctrl.sv
module plc_playout_ctrl
    import plc_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LEN_W = 16,
    parameter int TMR_W = 20,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_up,
    input  logic             deg_defect,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic [CNT_W-1:0] cfg_prefill,
    input  logic [TMR_W-1:0] cfg_timeout,
    input  logic             pkt_valid,
    input  logic [31:0]      pkt_cw,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic             slot_req,
    output logic             play_valid,
    output logic [1:0]       play_sel,
    output logic             lost_evt,
    output logic             rx_evt,
    output logic             fault_req,
    output logic             loss_flag
);

    plc_state_e       state_q, state_n;
    logic             fmt_ok, lflag, accept, push, late;
    logic [SEQ_W-1:0] seq;
    logic [CNT_W-1:0] fill, occ;
    logic             empty, head_fill, head_l, take, flush;
    logic [TMR_W-1:0] tmr_q;
    logic [TMR_W:0]   tmr_inc;
    logic             timeout_hit, prefill_met;

    plc_cw_check #(.LEN_W(LEN_W)) u_cw (
        .vld_i     (pkt_valid),
        .cw_i      (pkt_cw),
        .len_i     (pkt_len),
        .cfg_len_i (cfg_len),
        .fmt_ok_o  (fmt_ok),
        .lflag_o   (lflag),
        .seq_o     (seq)
    );

    plc_seq_track #(.DEPTH(DEPTH)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (flush),
        .acc_i   (accept),
        .seq_i   (seq),
        .occ_i   (occ),
        .push_o  (push),
        .late_o  (late),
        .fill_o  (fill)
    );

    plc_slot_queue #(.DEPTH(DEPTH)) u_q (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (flush),
        .push_i      (push),
        .push_fill_i (fill),
        .push_l_i    (lflag),
        .take_i      (take),
        .occ_o       (occ),
        .empty_o     (empty),
        .head_fill_o (head_fill),
        .head_l_o    (head_l)
    );

    assign accept      = fmt_ok && link_up && (state_q != ST_DOWN);
    assign tmr_inc     = {1'b0, tmr_q} + 1'b1;
    assign timeout_hit = (state_q == ST_NORMAL) && link_up && !accept
                         && (tmr_inc >= {1'b0, cfg_timeout});
    assign flush       = !link_up || timeout_hit;
    assign take        = slot_req && (state_q == ST_NORMAL) && !empty;
    assign prefill_met = (occ >= cfg_prefill);

    // next-state decision
    always_comb begin
        state_n = state_q;
        if (!link_up) begin
            state_n = ST_DOWN;
        end else begin
            unique case (state_q)
                ST_DOWN:    state_n = ST_PREFILL;
                ST_PREFILL: if (prefill_met) state_n = ST_NORMAL;
                ST_NORMAL:  if (timeout_hit) state_n = ST_LOSS;
                ST_LOSS:    if (prefill_met) state_n = ST_NORMAL;
                default:    state_n = ST_DOWN;
            endcase
        end
    end

    // state register and loss timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_DOWN;
            tmr_q   <= '0;
        end else begin
            state_q <= state_n;
            if ((state_q != ST_NORMAL) || (state_n != ST_NORMAL) || accept) begin
                tmr_q <= '0;
            end else begin
                tmr_q <= tmr_inc[TMR_W-1:0];
            end
        end
    end

    // slot answers and events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            play_valid <= 1'b0;
            play_sel   <= SEL_FAULT;
            lost_evt   <= 1'b0;
            rx_evt     <= 1'b0;
        end else begin
            play_valid <= slot_req;
            rx_evt     <= push && !flush;
            lost_evt   <= take && head_fill;
            if (slot_req) begin
                if (state_q != ST_NORMAL || deg_defect) begin
                    play_sel <= SEL_FAULT;
                end else if (empty || head_fill) begin
                    play_sel <= SEL_FILL;
                end else if (head_l) begin
                    play_sel <= SEL_FAULT;
                end else begin
                    play_sel <= SEL_DATA;
                end
            end
        end
    end

    always_comb begin
        fault_req = (state_q != ST_NORMAL) || deg_defect;
        loss_flag = (state_q == ST_LOSS) || deg_defect;
    end

    AST_SLOT_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        slot_req |=> play_valid); // R6
    AST_NO_SPURIOUS_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_req |=> !play_valid); // R6
    AST_FAULT_OUTSIDE_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_req && state_q != ST_NORMAL) |=> (play_sel == SEL_FAULT)); // R5
    AST_DOWN_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up |=> (occ == '0)); // R4
    AST_RX_CLEAN_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        rx_evt |-> ($past(pkt_valid) && $past(pkt_cw[31:28]) == 4'h0)); // R2
    AST_RX_LEN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        rx_evt |-> ($past(pkt_len) == $past(cfg_len))); // R3
    AST_RX_NOT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        rx_evt |-> ($past(state_q) != ST_DOWN)); // R13
    AST_LATE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        late |=> !rx_evt); // R8
    AST_PREFILL_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NORMAL && $past(state_q) == ST_PREFILL)
            |-> ($past(occ) >= $past(cfg_prefill))); // R5
    AST_LOSS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOSS && $past(state_q) == ST_NORMAL)
            |-> (!$past(fmt_ok) && occ == '0)); // R10

endmodule

// File: tb/sim_plc_playout_ctrl.sv
module sim_plc_playout_ctrl;

    localparam int DEPTH = 8;
    localparam int TMR_W = 12;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             link_up = 1'b0;
    logic             deg_defect = 1'b0;
    logic [15:0]      cfg_len = 16'd1024;
    logic [CNT_W-1:0] cfg_prefill = CNT_W'(3);
    logic [TMR_W-1:0] cfg_timeout = TMR_W'(60);
    logic             pkt_valid = 1'b0;
    logic [31:0]      pkt_cw = '0;
    logic [15:0]      pkt_len = '0;
    logic             slot_req = 1'b0;
    logic             play_valid, lost_evt, rx_evt, fault_req, loss_flag;
    logic [1:0]       play_sel;

    always #5 clk = ~clk;

    plc_playout_ctrl #(.DEPTH(DEPTH), .LEN_W(16), .TMR_W(TMR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .link_up(link_up), .deg_defect(deg_defect),
        .cfg_len(cfg_len), .cfg_prefill(cfg_prefill), .cfg_timeout(cfg_timeout),
        .pkt_valid(pkt_valid), .pkt_cw(pkt_cw), .pkt_len(pkt_len), .slot_req(slot_req),
        .play_valid(play_valid), .play_sel(play_sel), .lost_evt(lost_evt),
        .rx_evt(rx_evt), .fault_req(fault_req), .loss_flag(loss_flag)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;
    string cur_req = "R1";

    // slot-level reference model: 0 replacement for lost, 1 data, 2 fault (L flag)
    int mq[$];
    int ms = 0, mtmr = 0, mexp = 0, msel = 0;
    int kk, diff, avail, f, pre;
    bit mhave = 0, good, acc, m_pv = 0, m_lost = 0, m_rx = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete(); ms = 0; mtmr = 0; mhave = 0; msel = 0;
            m_pv = 0; m_lost = 0; m_rx = 0;
        end else begin
            good = pkt_valid && pkt_cw[31:28] == 4'h0 && pkt_len == cfg_len && link_up;
            acc  = good && ms != 0;
            pre  = mq.size();
            m_pv = slot_req; m_lost = 0; m_rx = 0;
            if (slot_req) begin
                if (ms != 2) msel = 0;
                else if (pre == 0) msel = deg_defect ? 0 : 2;
                else begin
                    kk = mq.pop_front();
                    if (kk == 0) begin m_lost = 1; msel = deg_defect ? 0 : 2; end
                    else if (kk == 1) msel = deg_defect ? 0 : 1;
                    else msel = 0;
                end
            end
            if (acc) begin
                diff = (int'(pkt_cw[15:0]) - mexp) & 16'hFFFF;
                if (!(mhave && diff >= 32768)) begin
                    avail = DEPTH - pre;
                    if (avail > 0) begin
                        f = mhave ? ((diff < avail - 1) ? diff : avail - 1) : 0;
                        for (int i = 0; i < f; i++) mq.push_back(0);
                        mq.push_back(pkt_cw[27] ? 2 : 1);
                        m_rx = 1;
                    end
                    mexp = (int'(pkt_cw[15:0]) + 1) & 16'hFFFF;
                    mhave = 1;
                end
            end
            if (!link_up) begin
                ms = 0; mq.delete(); mhave = 0; mtmr = 0; m_rx = 0;
            end else begin
                case (ms)
                    0: ms = 1;
                    1: if (pre >= int'(cfg_prefill)) ms = 2;
                    2: if (good) mtmr = 0;
                       else if (mtmr + 1 >= int'(cfg_timeout)) begin
                           ms = 3; mq.delete(); mhave = 0; mtmr = 0;
                       end else mtmr++;
                    default: if (pre >= int'(cfg_prefill)) ms = 2;
                endcase
            end
        end
    end

    task automatic chk(input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s act=%0d exp=%0d", cur_req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #2;
        if (!done) begin
            chk(play_valid, m_pv, "play_valid");
            if (m_pv) chk(play_sel, msel, "play_sel");
            chk(lost_evt, m_lost, "lost_evt");
            chk(rx_evt, m_rx, "rx_evt");
            chk(fault_req, (ms != 2) || deg_defect, "fault_req");
            chk(loss_flag, (ms == 3) || deg_defect, "loss_flag");
        end
    end

    function automatic logic [31:0] mkcw(input int s, input bit l);
        return {4'h0, l, 1'b0, 2'b00, 2'b00, 6'h00, 16'(s)};
    endfunction

    task automatic step(input bit pv, input logic [31:0] cw, input logic [15:0] ln, input bit sr);
        pkt_valid = pv; pkt_cw = cw; pkt_len = ln; slot_req = sr;
        @(negedge clk);
        pkt_valid = 0; slot_req = 0;
    endtask

    task automatic pkt(input int s);
        step(1, mkcw(s, 0), 16'd1024, 0);
    endtask

    task automatic slots(input int n);
        for (int i = 0; i < n; i++) step(0, '0, '0, 1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, '0, '0, 0);
    endtask

    initial begin
        @(negedge clk);
        idle(4);
        cur_req = "R1";
        chk(fault_req, 1, "reset fault_req");
        chk(loss_flag, 0, "reset loss_flag");
        chk(play_valid, 0, "reset play_valid");
        rst_n = 1;
        idle(2);

        cur_req = "R4";
        pkt(5); step(1, mkcw(6, 0), 16'd1024, 1); slots(2);
        chk(fault_req, 1, "down fault_req");

        cur_req = "R5";
        link_up = 1; idle(2);
        step(1, mkcw(100, 0), 16'd1024, 1); slots(1); pkt(101); idle(2);
        chk(fault_req, 1, "prefill not met");
        pkt(102); idle(2);
        chk(fault_req, 0, "prefill met");

        cur_req = "R6";
        slots(3);
        pkt(103); slots(1); pkt(104); pkt(105); slots(2);

        cur_req = "R13";
        pkt(106); slots(1);

        cur_req = "R2";
        step(1, {4'h1, 12'h000, 16'd107}, 16'd1024, 0);
        step(1, {4'h0, 1'b0, 1'b1, 2'b11, 2'b11, 6'h3F, 16'd107}, 16'd1024, 0);
        slots(2);

        cur_req = "R3";
        step(1, mkcw(108, 0), 16'd1000, 0); pkt(108); slots(2);

        cur_req = "R7";
        pkt(112); slots(5);
        pkt(200); slots(9);
        for (int s = 201; s <= 209; s++) pkt(s);
        slots(9);

        cur_req = "R8";
        pkt(215); pkt(212); slots(7);

        cur_req = "R9";
        step(1, mkcw(216, 1), 16'd1024, 0); pkt(217); slots(2);

        cur_req = "R11";
        deg_defect = 1; pkt(218); pkt(219); slots(1); idle(1);
        chk(loss_flag, 1, "deg loss_flag");
        chk(fault_req, 1, "deg fault_req");
        deg_defect = 0;

        cur_req = "R12";
        slots(3);

        cur_req = "R6";
        pkt(16'hFFFE); slots(8);
        pkt(16'hFFFF); pkt(0); pkt(1); slots(3);

        cur_req = "R10";
        idle(70);
        chk(loss_flag, 1, "timeout loss");
        slots(2); pkt(40); pkt(41); pkt(42); idle(2);
        chk(loss_flag, 0, "refilled");
        slots(3);

        cur_req = "R4";
        pkt(43); pkt(44); link_up = 0; idle(2); link_up = 1; idle(2);
        chk(fault_req, 1, "link drop back to prefill");
        slots(2);
        idle(3);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule